// File: doc/BRIEF.md
# Segment Offset Limit and Type Checker

This block decides, for one memory access at a time, whether a 16-bit offset may be used against a segment. The segment is described by its 16-bit limit and its 8-bit access byte. Each request carries the access byte, the limit, the offset, the access size in bytes and a read/write flag, and it is qualified by a valid strobe. One cycle later the block reports two independent results. The first is a limit fault, when a byte touched by the access lies outside the segment. The second is a type fault, when the segment's kind does not allow the requested direction.

The access byte decides how the limit is read. A normal data segment grows upward from offset 0 to the limit. An expand-down data segment holds only the offsets strictly above the limit, so a limit of FFFFH leaves it empty and a limit of 0 gives it every offset except 0. Code segments always use the upward rule.

On every accepted request whose accessed bit is clear, the block also raises a write-back enable and presents the access byte with that bit set, so that the surrounding logic can update the stored descriptor. Address formation, fault dispatch and the memory write itself belong to other blocks.

Top module: `seg_limit_check`

## Requirements
- R1: Access byte fields: bit 3 set marks a code segment, clear marks a data segment. Bit 2 set on a data segment marks it expand-down. Bit 1 is write-enable for data and read-enable for code. Bit 0 is the accessed flag.
- R2: For an expand-up data segment, limit_fault_o is set when any touched byte offset is greater than the limit.
- R3: For an expand-down data segment, limit_fault_o is set when any touched byte offset is less than or equal to the limit. With limit FFFFH every offset faults, and with limit 0 only offset 0 faults for a one-byte access.
- R4: A request with size_i = 2 touches both offset and offset+1. If offset+1 carries out of 16 bits, the result is a limit fault under every segment kind. size_i = 1 touches the offset alone.
- R5: A write to a data segment with bit 1 clear sets type_fault_o. Reads from data segments never set it.
- R6: A read from a code segment sets type_fault_o when bit 1 is clear, and a write to a code segment always sets it. Code segments use the rule of R2 whatever the value of bit 2.
- R7: wb_en_o is set for an accepted request exactly when bit 0 of its access byte was 0. wb_byte_o is then that access byte with bit 0 forced to 1. This happens whether or not a fault is reported.
- R8: All results appear on the outputs on the clock edge after the one that samples valid_i high, with valid_o high. In a cycle that follows no accepted request, valid_o, both faults and wb_en_o are 0.
- R9: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| acc_byte_i | input | 8 | Segment access byte |
| limit_i | input | 16 | Segment limit |
| offset_i | input | 16 | Offset of the first byte accessed |
| size_i | input | 2 | Access size in bytes, 1 or 2 |
| write_i | input | 1 | 1 for a write, 0 for a read |
| valid_o | output | 1 | Results are valid |
| limit_fault_o | output | 1 | Offset outside the segment |
| type_fault_o | output | 1 | Direction not allowed for the segment kind |
| wb_en_o | output | 1 | Access byte needs its accessed bit written back |
| wb_byte_o | output | 8 | Access byte with the accessed bit set |

## Verification
The bench builds the block with its default widths: a 16-bit offset and limit and a 2-bit size field. These widths put the carry out of offset FFFFH and both ends of the expand-down range, limits 0 and FFFFH, within a handful of vectors. Under the same limit, the bench compares expand-up, expand-down and code segments on both sides of the boundary. It checks the write-back byte for descriptors that are already accessed and for those that are not.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned AB_W        = 8;
  localparam int unsigned AB_CODE_BIT = 3;
  localparam int unsigned AB_DOWN_BIT = 2;
  localparam int unsigned AB_RW_BIT   = 1;
  localparam int unsigned AB_ACC_BIT  = 0;

  typedef enum logic [1:0] {
    SEG_DATA_UP = 2'd0,
    SEG_DATA_DN = 2'd1,
    SEG_CODE    = 2'd2
  } seg_kind_e;
endpackage

// File: rtl/seg_kind_decode.sv
module seg_kind_decode
  import seg_chk_pkg::*;
(
  input  logic [AB_W-1:0] acc_byte_i,
  output seg_kind_e       kind_o,
  output logic            rw_en_o
);
  always_comb begin
    if (acc_byte_i[AB_CODE_BIT])      kind_o = SEG_CODE;
    else if (acc_byte_i[AB_DOWN_BIT]) kind_o = SEG_DATA_DN;
    else                              kind_o = SEG_DATA_UP;
  end

  assign rw_en_o = acc_byte_i[AB_RW_BIT];

  always_comb begin
    if (acc_byte_i[AB_CODE_BIT])
      assert_code_not_down_R6: assert (kind_o == SEG_CODE);
  end
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp
  import seg_chk_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SIZE_W = 2
) (
  input  seg_kind_e         kind_i,
  input  logic [OFF_W-1:0]  limit_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              fault_o
);
  localparam int unsigned EXT_W = OFF_W + 1;

  logic [EXT_W-1:0] span;
  logic [EXT_W-1:0] last_ext;
  logic             carry;
  logic [OFF_W-1:0] last_off;
  logic             up_fault;
  logic             dn_fault;

  // size 0 is treated as a single byte
  always_comb begin
    if (size_i == '0) span = '0;
    else              span = {{(EXT_W-SIZE_W){1'b0}}, size_i} - EXT_W'(1);
  end

  assign last_ext = {1'b0, offset_i} + span;
  assign carry    = last_ext[OFF_W];
  assign last_off = last_ext[OFF_W-1:0];

  // expand-up: last byte bounds the access
  assign up_fault = carry || (last_off > limit_i);
  // expand-down: first byte bounds the access, wrap is a fault
  assign dn_fault = carry || (offset_i <= limit_i);

  assign fault_o = (kind_i == SEG_DATA_DN) ? dn_fault : up_fault;

  always_comb begin
    if (kind_i == SEG_DATA_DN && limit_i == '1)
      assert_empty_down_seg_R3: assert (fault_o);
    if (kind_i != SEG_DATA_DN && offset_i > limit_i)
      assert_up_past_limit_R2: assert (fault_o);
  end
endmodule

// File: rtl/seg_type_check.sv
module seg_type_check
  import seg_chk_pkg::*;
(
  input  seg_kind_e kind_i,
  input  logic      rw_en_i,
  input  logic      write_i,
  output logic      fault_o
);
  always_comb begin
    unique case (kind_i)
      SEG_CODE: fault_o = write_i || !rw_en_i;
      default:  fault_o = write_i && !rw_en_i;
    endcase
  end

  always_comb begin
    if (kind_i == SEG_CODE && write_i)
      assert_code_write_R6: assert (fault_o);
    if (kind_i != SEG_CODE && !write_i)
      assert_data_read_ok_R5: assert (!fault_o);
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_chk_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SIZE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [AB_W-1:0]   acc_byte_i,
  input  logic [OFF_W-1:0]  limit_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic              limit_fault_o,
  output logic              type_fault_o,
  output logic              wb_en_o,
  output logic [AB_W-1:0]   wb_byte_o
);
  seg_kind_e kind;
  logic      rw_en;
  logic      lim_flt;
  logic      typ_flt;
  logic [AB_W-1:0] upd_byte;

  seg_kind_decode u_decode (
    .acc_byte_i (acc_byte_i),
    .kind_o     (kind),
    .rw_en_o    (rw_en)
  );

  seg_limit_cmp #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_limit (
    .kind_i   (kind),
    .limit_i  (limit_i),
    .offset_i (offset_i),
    .size_i   (size_i),
    .fault_o  (lim_flt)
  );

  seg_type_check u_type (
    .kind_i  (kind),
    .rw_en_i (rw_en),
    .write_i (write_i),
    .fault_o (typ_flt)
  );

  always_comb begin
    upd_byte             = acc_byte_i;
    upd_byte[AB_ACC_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      limit_fault_o <= 1'b0;
      type_fault_o  <= 1'b0;
      wb_en_o       <= 1'b0;
      wb_byte_o     <= '0;
    end else begin
      valid_o       <= valid_i;
      limit_fault_o <= valid_i && lim_flt;
      type_fault_o  <= valid_i && typ_flt;
      wb_en_o       <= valid_i && !acc_byte_i[AB_ACC_BIT];
      if (valid_i) wb_byte_o <= upd_byte;
    end
  end

  assert_valid_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(limit_fault_o || type_fault_o || wb_en_o));
  assert_wb_byte_marked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_byte_o[AB_ACC_BIT]);
  assert_wb_only_when_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_byte_i[AB_ACC_BIT]) |=> !wb_en_o);
  assert_word_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SIZE_W'(2) && offset_i == '1) |=> limit_fault_o);
endmodule

// File: tb/seg_limit_check_bench.sv
module seg_limit_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  ab = '0;
  logic [15:0] lim = '0;
  logic [15:0] off = '0;
  logic [1:0]  sz = 2'd1;
  logic        wr = 1'b0;
  logic        v_o, lf_o, tf_o, wbe_o;
  logic [7:0]  wbb_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seg_limit_check u_seg_limit_check (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .acc_byte_i(ab),
    .limit_i(lim), .offset_i(off), .size_i(sz), .write_i(wr),
    .valid_o(v_o), .limit_fault_o(lf_o), .type_fault_o(tf_o),
    .wb_en_o(wbe_o), .wb_byte_o(wbb_o)
  );

  // {access byte, limit, offset, size, write, exp limit fault, exp type fault}
  localparam int NV = 17;
  localparam logic [44:0] VEC [NV] = '{
    {8'h02, 16'h0010, 16'h0010, 2'd1, 1'b0, 1'b0, 1'b0}, // R2 at limit
    {8'h02, 16'h0010, 16'h0011, 2'd1, 1'b0, 1'b1, 1'b0}, // R2 past limit
    {8'h02, 16'h0010, 16'h000F, 2'd2, 1'b1, 1'b0, 1'b0}, // R4 word ends at limit
    {8'h02, 16'h0010, 16'h0010, 2'd2, 1'b1, 1'b1, 1'b0}, // R4 word crosses limit
    {8'h03, 16'hFFFF, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1'b0}, // R4 carry, up
    {8'h06, 16'h0000, 16'h0000, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 limit 0, off 0
    {8'h06, 16'h0000, 16'h0001, 2'd1, 1'b0, 1'b0, 1'b0}, // R3 limit 0, off 1
    {8'h06, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 empty segment
    {8'h06, 16'h8000, 16'h8001, 2'd2, 1'b1, 1'b0, 1'b0}, // R3 word above limit
    {8'h06, 16'h8000, 16'h8000, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 equal to limit
    {8'h06, 16'h0000, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1'b0}, // R4 carry, down
    {8'h00, 16'hFFFF, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1}, // R5 protected write
    {8'h00, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0}, // R5 protected read
    {8'h0A, 16'h00FF, 16'h00FF, 2'd1, 1'b0, 1'b0, 1'b0}, // R6 readable code
    {8'h08, 16'h00FF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1}, // R6 execute-only read
    {8'h0B, 16'h00FF, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1}, // R6 code write
    {8'h0E, 16'h0010, 16'h0011, 2'd1, 1'b0, 1'b1, 1'b0}  // R6 code ignores bit 2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [44:0] v);
    @(negedge clk);
    ab = v[44:37]; lim = v[36:21]; off = v[20:5]; sz = v[4:3]; wr = v[2];
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 valid", 32'(v_o), 0);
    chk("R9 faults", 32'({lf_o, tf_o, wbe_o}), 0);
    chk("R9 byte", 32'(wbb_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      chk("R8 valid", 32'(v_o), 1);
      chk($sformatf("R2/R3/R4 limit vec %0d", i), 32'(lf_o), 32'(VEC[i][1]));
      chk($sformatf("R5/R6 type vec %0d", i), 32'(tf_o), 32'(VEC[i][0]));
      chk($sformatf("R7 wb_en vec %0d", i), 32'(wbe_o), 32'(!VEC[i][37]));
      if (!VEC[i][37])
        chk($sformatf("R7 wb_byte vec %0d", i), 32'(wbb_o), 32'(VEC[i][44:37] | 8'h01));
    end

    // R1: same limit and offset, only the kind bits differ
    issue({8'h02, 16'h0100, 16'h0200, 2'd1, 1'b0, 2'b00});
    chk("R1 up kind", 32'(lf_o), 1);
    issue({8'h06, 16'h0100, 16'h0200, 2'd1, 1'b0, 2'b00});
    chk("R1 down kind", 32'(lf_o), 0);
    issue({8'h0E, 16'h0100, 16'h0200, 2'd1, 1'b0, 2'b00});
    chk("R1 code kind", 32'(lf_o), 1);

    // R7: faulting access still writes back
    issue({8'h04, 16'hFFFF, 16'h1234, 2'd1, 1'b1, 2'b00});
    chk("R7 faulted wb_en", 32'(wbe_o), 1);
    chk("R7 faulted wb_byte", 32'(wbb_o), 32'h05);
    chk("R7 faulted both", 32'({lf_o, tf_o}), 32'b11);

    // R8: idle cycle after a faulting request
    issue({8'h08, 16'h0000, 16'hFFFF, 2'd2, 1'b1, 2'b00});
    @(negedge clk);
    chk("R8 idle valid", 32'(v_o), 0);
    chk("R8 idle outputs", 32'({lf_o, tf_o, wbe_o}), 0);

    // R9: reset mid-stream clears outputs
    issue({8'h08, 16'h0000, 16'hFFFF, 2'd2, 1'b1, 2'b00});
    rst_n = 1'b0;
    #1;
    chk("R9 reset clears", 32'({v_o, lf_o, tf_o, wbe_o}), 0);
    chk("R9 reset byte", 32'(wbb_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule